// File: doc/BRIEF.md
# Reconfigurable Region Isolation Controller

This block keeps a reconfigurable logic region apart from the rest of the chip. Software drives it before and after that region is reprogrammed. It sits behind a small 32-bit register port. Toward the region it drives a hold line, which isolates the region's traffic, and a reset line. From the region it takes an acknowledge that says traffic has drained.

The block has two settled states: released (traffic flows) and held (traffic isolated). It moves between them through a short handshake and reports the result in two done flags. Exactly one of the two flags is set at any time.

The usual software flow is:
- Request the hold, then wait for the held flag.
- Pulse the region reset.
- Clear the control word.
- Request the release, then wait for the released flag.

Some writes come in a state where they make no sense. Such a write is not executed. Instead a code is latched in a capture register that software clears by writing a one. Redundant requests (hold while held, release while released) are accepted quietly and do nothing.

Top module: `region_isolator`

## Requirements
- R1: After reset, the status word reads 2 (bit 1 = released done, bit 0 = held done clear). The control, capture and outputs read 0.
- R2: Byte offset 12 always reads the constant 0xAD000003, or 2 when LEGACY_VER is set. Offsets are 0 status, 4 control, 8 capture, 12 version; address bits 1:0 are ignored.
- R3: A legal control write with bit 0 (hold request) while released drives `hold_o` high from the next cycle. Status stays 2 until `drain_ack` is sampled high. Status reads 1 from the cycle after that.
- R4: Suppose `drain_ack` never comes. The hold completes after DRAIN_LIMIT clock edges counted from the edge that accepted the request.
- R5: A legal control write with bit 2 (release request) while held drops `hold_o` from the next cycle. Status stays 1 for REL_CYCLES edges and then reads 2.
- R6: Exactly one of status bits 0 and 1 is set in every cycle.
- R7: `region_rst_o` is high only while control bit 1 is set and the block is settled held.
- R8: Two control writes are illegal and are otherwise ignored: control and state stay unchanged. One sets both bit 0 and bit 2, and sets capture bit 0. The other sets bit 1 while the block is not settled held, and sets capture bit 1. A captured bit stays set until it is cleared.
- R9: A write to offset 8 with bit 0 set clears the capture register. A write there with bit 0 clear changes nothing.
- R10: Writing 0 to control clears the stored control bits and leaves the held or released state unchanged. A drain completion in the same cycle as that write still takes effect.
- R11: A hold request while held, or a release request while released, changes no state and sets no capture bit. The value is still stored in control.
- R12: `drain_ack` has no effect outside the draining phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| drain_ack | input | 1 | Region reports that its traffic has drained |
| hold_o | output | 1 | Isolates the region while high |
| region_rst_o | output | 1 | Reset toward the region |

## Verification
A drain completion and a software write to control can land on the same clock edge. The bench provokes this by holding `drain_ack` high while writing 0 to control in one cycle during a drain. It then expects three results together: status reads 1, control reads 0 and `hold_o` stays high. So neither action may mask the other. The illegal-write table shows that rejected writes leave control and status untouched while the capture bits record each offending condition.

// File: rtl/region_isolator.sv
`timescale 1ns/1ps
module region_isolator #(
  parameter int DRAIN_LIMIT = 16,
  parameter int REL_CYCLES  = 4,
  parameter bit LEGACY_VER  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        drain_ack,
  output logic        hold_o,
  output logic        region_rst_o
);
  localparam int CNT_MAX = (DRAIN_LIMIT > REL_CYCLES) ? DRAIN_LIMIT : REL_CYCLES;
  localparam int CW = $clog2(CNT_MAX) + 1;
  localparam logic [31:0] VERSION = LEGACY_VER ? 32'd2 : 32'hAD00_0003;

  typedef enum logic [1:0] {S_RELEASED, S_DRAIN, S_HELD, S_RELEASE} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [2:0]    ctrl_q;
  logic [1:0]    cap_q;
  logic          held_done, rel_done;

  wire sel_ctrl = wr_en && (addr[3:2] == 2'd1);
  wire sel_cap  = wr_en && (addr[3:2] == 2'd2);
  wire both_bad = wdata[0] && wdata[2];
  wire rst_bad  = wdata[1] && (st != S_HELD);
  wire bad_wr   = sel_ctrl && (both_bad || rst_bad);
  wire ctrl_ok  = sel_ctrl && !bad_wr;

  assign hold_o       = (st == S_DRAIN) || (st == S_HELD);
  assign region_rst_o = ctrl_q[1] && (st == S_HELD);

  always_comb begin
    case (addr[3:2])
      2'd0:    rdata = {30'd0, rel_done, held_done};
      2'd1:    rdata = {29'd0, ctrl_q};
      2'd2:    rdata = {30'd0, cap_q};
      default: rdata = VERSION;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RELEASED;
      cnt       <= '0;
      ctrl_q    <= '0;
      cap_q     <= '0;
      held_done <= 1'b0;
      rel_done  <= 1'b1;
    end else begin
      if (ctrl_ok) ctrl_q <= wdata[2:0];
      if (bad_wr) cap_q <= cap_q | {rst_bad, both_bad};
      else if (sel_cap && wdata[0]) cap_q <= '0;
      case (st)
        S_RELEASED: if (ctrl_ok && wdata[0]) begin
          st  <= S_DRAIN;
          cnt <= '0;
        end
        S_DRAIN: if (drain_ack || cnt == CW'(DRAIN_LIMIT - 1)) begin
          st        <= S_HELD;
          held_done <= 1'b1;
          rel_done  <= 1'b0;
        end else cnt <= cnt + 1'b1;
        S_HELD: if (ctrl_ok && wdata[2]) begin
          st  <= S_RELEASE;
          cnt <= '0;
        end
        default: if (cnt == CW'(REL_CYCLES - 1)) begin
          st        <= S_RELEASED;
          rel_done  <= 1'b1;
          held_done <= 1'b0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R6
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({held_done, rel_done}));

  // R7
  rst_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_rst_o |-> (hold_o && held_done));

  // R8
  illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(ctrl_q));

  // R3
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ok && wdata[0] && rel_done && !hold_o) |=> (hold_o && rel_done));

  // R5
  release_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ok && wdata[2] && held_done && hold_o) |=> (!hold_o && held_done));

  // R4
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && rel_done) |-> (cnt < CW'(DRAIN_LIMIT)));
endmodule

// File: tb/test_region_isolator.sv
`timescale 1ns/1ps
module test_region_isolator;
  localparam int DL = 16;
  localparam int RC = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, drain_ack = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic hold_o, region_rst_o;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  region_isolator #(.DRAIN_LIMIT(DL), .REL_CYCLES(RC), .LEGACY_VER(1'b0)) i_region_isolator (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .drain_ack(drain_ack), .hold_o(hold_o), .region_rst_o(region_rst_o));

  // {control value written while released, expected capture code}
  localparam logic [4:0] VEC [7] = '{
    {3'd0, 2'd0}, {3'd2, 2'd2}, {3'd5, 2'd1}, {3'd4, 2'd0},
    {3'd7, 2'd3}, {3'd3, 2'd2}, {3'd6, 2'd2}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(4'd0, d);  chk("R1 status", d, 32'd2);
    rd(4'd4, d);  chk("R1 control", d, 32'd0);
    rd(4'd8, d);  chk("R1 capture", d, 32'd0);
    chk("R1 outputs", {hold_o, region_rst_o}, 2'b00);
    rd(4'd12, d); chk("R2 version", d, 32'hAD00_0003);
    rd(4'd13, d); chk("R2 low bits ignored", d, 32'hAD00_0003);

    drain_ack = 1'b1; @(negedge clk); drain_ack = 1'b0;
    rd(4'd0, d); chk("R12 ack while released", {d[1:0], hold_o}, 3'b100);

    for (int i = 0; i < 7; i++) begin
      wr(4'd4, {29'd0, VEC[i][4:2]});
      rd(4'd8, d); chk("R8 capture code", d, {30'd0, VEC[i][1:0]});
      rd(4'd4, d); chk("R8/R11 control", d, (VEC[i][1:0] == 2'd0) ? {29'd0, VEC[i][4:2]} : 32'd0);
      rd(4'd0, d); chk("R8/R11 state", {d[1:0], hold_o, region_rst_o}, 4'b1000);
      wr(4'd4, 32'd0);
      wr(4'd8, 32'd1);
    end

    wr(4'd4, 32'd1);
    rd(4'd0, d); chk("R3 hold asserted, status pending", {d[1:0], hold_o}, 3'b101);
    repeat (3) @(negedge clk);
    rd(4'd0, d); chk("R3 waits for ack", d, 32'd2);
    drain_ack = 1'b1; @(negedge clk); drain_ack = 1'b0;
    rd(4'd0, d); chk("R3 held done", {d[1:0], hold_o}, 3'b011);

    wr(4'd4, 32'd1);
    rd(4'd0, d); chk("R11 hold while held", {d[1:0], hold_o}, 3'b011);
    rd(4'd8, d); chk("R11 no capture", d, 32'd0);

    wr(4'd4, 32'd2);
    chk("R7 region reset while held", region_rst_o, 1'b1);
    wr(4'd4, 32'd0);
    chk("R7 region reset dropped", region_rst_o, 1'b0);
    rd(4'd0, d); chk("R10 zero keeps held", {d[1:0], hold_o}, 3'b011);

    wr(4'd4, 32'd4);
    rd(4'd0, d); chk("R5 hold dropped, status held", {d[1:0], hold_o}, 3'b010);
    repeat (RC - 1) @(negedge clk);
    rd(4'd0, d); chk("R5 still held before count", d, 32'd1);
    @(negedge clk);
    rd(4'd0, d); chk("R5 released done", d, 32'd2);

    wr(4'd4, 32'd0);
    wr(4'd4, 32'd1);
    repeat (DL - 1) @(negedge clk);
    rd(4'd0, d); chk("R4 before drain limit", d, 32'd2);
    @(negedge clk);
    rd(4'd0, d); chk("R4 drain limit reached", d, 32'd1);

    wr(4'd4, 32'd7);
    rd(4'd8, d); chk("R8 both requests while held", d, 32'd1);
    rd(4'd0, d); chk("R8 state unchanged", {d[1:0], hold_o}, 3'b011);
    wr(4'd8, 32'd0);
    rd(4'd8, d); chk("R9 write of zero keeps capture", d, 32'd1);
    wr(4'd8, 32'd1);
    rd(4'd8, d); chk("R9 clear", d, 32'd0);

    wr(4'd4, 32'd0);
    wr(4'd4, 32'd4);
    repeat (RC) @(negedge clk);
    wr(4'd4, 32'd1);
    @(negedge clk);
    drain_ack = 1'b1; addr = 4'd4; wdata = 32'd0; wr_en = 1'b1;
    @(negedge clk);
    drain_ack = 1'b0; wr_en = 1'b0;
    rd(4'd0, d); chk("R10 completion with zero write", {d[1:0], hold_o}, 3'b011);
    rd(4'd4, d); chk("R10 control cleared", d, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule